// File: doc/BRIEF.md
# Stochastic Bitstream Multiplier

This block multiplies two unsigned fractions in the range zero to one by turning each into a serial pseudo-random bitstream and combining the streams with a single AND gate. In every cycle of a run, each operand is compared with the upper bits of its own linear-feedback shift register. The comparison gives a 1 with a probability equal to the operand's value. The AND of the two bits is a 1 with a probability equal to the product. A counter tallies the ones over a run length chosen at start time, and the tally divided by the length is the estimate of the product.

Precision comes from the run length, not from datapath width. A longer run costs more cycles and gives a tighter estimate, while the hardware stays the same. Each operand has OPW fractional bits plus one integer bit, so the code 2^OPW is exactly 1.0. Both generators are reloaded with fixed nonzero seeds at every accepted start, so a given set of inputs always produces the same count.

Top module: `sbm_mult`

## Requirements
- R1: After reset, busy, done and count are all 0.
- R2: A start pulse while busy is 0 captures both operands and the length. Busy rises on the next cycle and count reads 0 on the next cycle.
- R3: A stream bit is 1 when the top OPW bits of its generator are strictly below the operand. An operand of 0 never yields a 1. An operand of 2^OPW or more (256 by default) always yields a 1. So both operands at 256 give count equal to the length, and any zero operand gives count 0.
- R4: Each run cycle adds the AND of the two stream bits to count. For a length of 1024 or more, the final count lies within length/8+16 of length*a*b/2^(2*OPW).
- R5: Done is high for exactly one cycle, on the length-th cycle after the start edge. Busy is low while done is high. Count keeps its final value until the next accepted start.
- R6: A start with length 0 produces no run. Done pulses on the next cycle and count is 0.
- R7: A start pulse while busy is 1 is ignored. The operands, the length and the completion time of the current run do not change.
- R8: The two generators use different feedback polynomials and different nonzero seeds, and both are reloaded at each accepted start. Identical inputs give identical counts.
- R9: During a run, count rises by at most one per cycle and never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| op_a | input | OPW+1 | First operand, 2^OPW equals 1.0 |
| op_b | input | OPW+1 | Second operand, 2^OPW equals 1.0 |
| length | input | LW | Number of stream bits in the run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| count | output | LW | Number of ones in the product stream |

## Verification
A five-by-five grid of operand values, each run for 1024 bits, separates the exact corners from the estimated interior. A zero operand must give a count of exactly 0 and two full-scale operands must give exactly the length. The mixed points must land near the arithmetic product, which catches a comparator that is off by one or a swapped operand. A sweep of lengths from 0 to 4096 with full-scale operands pins down the done timing and the final count exactly. Further runs check that a start during a run is ignored and that a repeated run reproduces its count.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   // feedback masks: bit t-1 set for polynomial term x^t
   localparam logic [15:0] SBM_TAPS_A = 16'hD008;  // x16+x15+x13+x4+1
   localparam logic [15:0] SBM_TAPS_B = 16'hB400;  // x16+x14+x13+x11+1
   localparam logic [15:0] SBM_SEED_A = 16'hACE1;
   localparam logic [15:0] SBM_SEED_B = 16'h5A3C;

   typedef enum logic {
      SBM_FIBONACCI = 1'b0,
      SBM_GALOIS    = 1'b1
   } sbm_lfsr_kind_e;
endpackage

// File: rtl/sbm_lfsr.sv
module sbm_lfsr
   import sbm_pkg::*;
#(
   parameter int             W      = 16,
   parameter logic [W-1:0]   TAPS   = SBM_TAPS_A,
   parameter logic [W-1:0]   SEED   = SBM_SEED_A,
   parameter sbm_lfsr_kind_e KIND   = SBM_FIBONACCI
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   output logic [W-1:0] state
);
   logic [W-1:0] nxt;

   generate
      if (SEED == '0) begin : g_bad_seed
         $error("sbm_lfsr: seed must be nonzero");
      end
      if (W < 2) begin : g_bad_width
         $error("sbm_lfsr: width too small");
      end

      if (KIND == SBM_GALOIS) begin : g_galois
         always_comb nxt = {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
      end else begin : g_fib
         always_comb nxt = {state[W-2:0], ^(state & TAPS)};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      state <= SEED;
      else if (load)   state <= SEED;
      else if (step)   state <= nxt;
   end
endmodule

// File: rtl/sbm_bitgen.sv
module sbm_bitgen #(
   parameter int OPW = 8,
   parameter int RW  = 16
) (
   input  logic [RW-1:0] rnd,
   input  logic [OPW:0]  operand,
   output logic          bit_o
);
   localparam int TOP = RW - 1;

   generate
      if (RW < OPW) begin : g_bad
         $error("sbm_bitgen: generator narrower than operand");
      end
   endgenerate

   logic [OPW:0] sample;
   always_comb begin
      sample = {1'b0, rnd[TOP -: OPW]};
      bit_o  = (sample < operand);
   end
endmodule

// File: rtl/sbm_tally.sv
module sbm_tally #(
   parameter int LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [LW-1:0] length,
   input  logic          prod,
   output logic          busy,
   output logic          done,
   output logic [LW-1:0] count
);
   localparam logic [LW-1:0] ONE = LW'(1);

   logic [LW-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         count  <= '0;
         remain <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            count <= '0;
            if (length == '0) begin
               done <= 1'b1;
            end else begin
               busy   <= 1'b1;
               remain <= length;
            end
         end else if (busy) begin
            count  <= count + LW'(prod);
            remain <= remain - ONE;
            if (remain == ONE) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sbm_mult.sv
module sbm_mult
   import sbm_pkg::*;
#(
   parameter int             OPW    = 8,
   parameter int             LW     = 16,
   parameter int             RW     = 16,
   parameter logic [RW-1:0]  TAPS_A = SBM_TAPS_A,
   parameter logic [RW-1:0]  TAPS_B = SBM_TAPS_B,
   parameter logic [RW-1:0]  SEED_A = SBM_SEED_A,
   parameter logic [RW-1:0]  SEED_B = SBM_SEED_B,
   parameter sbm_lfsr_kind_e KIND   = SBM_FIBONACCI
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [OPW:0]  op_a,
   input  logic [OPW:0]  op_b,
   input  logic [LW-1:0] length,
   output logic          busy,
   output logic          done,
   output logic [LW-1:0] count
);
   localparam int NCH = 2;

   generate
      if (SEED_A == SEED_B) begin : g_same_seed
         $error("sbm_mult: the two streams need distinct seeds");
      end
      if (OPW < 1 || LW < 1) begin : g_bad_w
         $error("sbm_mult: widths must be positive");
      end
   endgenerate

   logic           accept;
   logic [OPW:0]   a_q, b_q;
   logic [OPW:0]   opnd [NCH];
   logic [RW-1:0]  rnd  [NCH];
   logic [NCH-1:0] sbit;
   logic           prod;

   assign accept  = start & ~busy;
   assign opnd[0] = a_q;
   assign opnd[1] = b_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (accept) begin
         a_q <= op_a;
         b_q <= op_b;
      end
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         sbm_lfsr #(
            .W    (RW),
            .TAPS (c == 0 ? TAPS_A : TAPS_B),
            .SEED (c == 0 ? SEED_A : SEED_B),
            .KIND (KIND)
         ) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (accept),
            .step  (busy),
            .state (rnd[c])
         );
         sbm_bitgen #(.OPW(OPW), .RW(RW)) u_gen (
            .rnd     (rnd[c]),
            .operand (opnd[c]),
            .bit_o   (sbit[c])
         );
      end
   endgenerate

   assign prod = &sbit;

   sbm_tally #(.LW(LW)) u_tally (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .length (length),
      .prod   (prod),
      .busy   (busy),
      .done   (done),
      .count  (count)
   );
endmodule

// File: rtl/sbm_mult_chk.sv
module sbm_mult_chk #(
   parameter int OPW = 8,
   parameter int LW  = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [LW-1:0] length,
   input logic          busy,
   input logic          done,
   input logic [LW-1:0] count,
   input logic [OPW:0]  a_q,
   input logic [OPW:0]  b_q,
   input logic          prod
);
   // R2
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && length != '0) |=> (busy && count == '0));

   // R6
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && length == '0) |=> (done && !busy && count == '0));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   // R5
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7
   hold_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(a_q) && $stable(b_q)));

   // R3
   zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (a_q == '0 || b_q == '0)) |-> !prod);

   // R9
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (count >= $past(count) && count <= $past(count) + LW'(1)));
endmodule

bind sbm_mult sbm_mult_chk #(.OPW(OPW), .LW(LW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .length (length),
   .busy   (busy),
   .done   (done),
   .count  (count),
   .a_q    (a_q),
   .b_q    (b_q),
   .prod   (prod)
);

// File: tb/tb_sbm_mult.sv
module tb_sbm_mult;
   localparam int OPW = 8;
   localparam int LW  = 16;
   localparam int FS  = 1 << OPW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [OPW:0]  op_a = '0;
   logic [OPW:0]  op_b = '0;
   logic [LW-1:0] length = '0;
   logic          busy, done;
   logic [LW-1:0] count;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   sbm_mult dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .length(length), .busy(busy), .done(done), .count(count)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // start at a negedge, return final count and negedges until done
   task automatic run(input int a, input int b, input int n, output int cnt, output int cyc);
      op_a = (OPW+1)'(a); op_b = (OPW+1)'(b); length = LW'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 70000) begin
         @(negedge clk);
         cyc++;
      end
      cnt = int'(count);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int cnt, cyc, cnt2, cyc2, c;
      int vals[5] = '{0, 64, 128, 192, 256};
      int lens[6] = '{1, 2, 3, 17, 300, 4096};
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0 && done == 0 && count == 0, "R1", {busy, done, count}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && count == 0, "R1", {busy, done, count}, 0);

      // R3 R4 R5 grid sweep
      foreach (vals[i]) begin
         foreach (vals[j]) begin
            longint e;
            int tol;
            run(vals[i], vals[j], 1024, cnt, cyc);
            chk(cyc == 1025, "R5", cyc, 1025);
            e   = (longint'(1024) * vals[i] * vals[j]) / (FS * FS);
            tol = 1024 / 8 + 16;
            if (vals[i] == 0 || vals[j] == 0)
               chk(cnt == 0, "R3", cnt, 0);
            else if (vals[i] == FS && vals[j] == FS)
               chk(cnt == 1024, "R3", cnt, 1024);
            else
               chk(cnt >= e - tol && cnt <= e + tol, "R4", cnt, e);
            @(negedge clk);
         end
      end

      // R3 R5 length sweep at full scale
      foreach (lens[k]) begin
         run(FS, FS, lens[k], cnt, cyc);
         chk(cnt == lens[k], "R3", cnt, lens[k]);
         chk(cyc == lens[k] + 1, "R5", cyc, lens[k] + 1);
         @(negedge clk);
         chk(done == 0, "R5", done, 0);
      end

      // R5 count held after done
      repeat (20) @(negedge clk);
      chk(int'(count) == 4096, "R5", count, 4096);

      // R6 zero length
      run(FS, FS, 0, cnt, cyc);
      chk(cyc == 1 && cnt == 0, "R6", cyc * 100000 + cnt, 100000);
      @(negedge clk);
      chk(done == 0 && busy == 0, "R6", {done, busy}, 0);

      // R2 R7 start during a run is ignored
      op_a = (OPW+1)'(FS); op_b = (OPW+1)'(FS); length = LW'(200); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1 && count == 0, "R2", {busy, count}, 65536);
      c = 1;
      repeat (50) begin @(negedge clk); c++; end
      op_a = '0; length = LW'(5); start = 1'b1;
      @(negedge clk); c++;
      start = 1'b0;
      while (!done && c < 1000) begin @(negedge clk); c++; end
      chk(c == 201, "R7", c, 201);
      chk(int'(count) == 200, "R7", count, 200);
      @(negedge clk);

      // R8 repeatability and R4 estimate
      run(100, 200, 2048, cnt, cyc);
      @(negedge clk);
      run(100, 200, 2048, cnt2, cyc2);
      chk(cnt == cnt2, "R8", cnt2, cnt);
      begin
         longint e = (longint'(2048) * 100 * 200) / (FS * FS);
         chk(cnt >= e - 272 && cnt <= e + 272, "R4", cnt, e);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule